// File: doc/BRIEF.md
# Zero-Suppressed Hit Packet Formatter

This block drains hit records out of one pixel column and turns each into a fixed 48-bit output word. Pixels are arranged in groups of eight. Only a pixel that holds a hit raises its request line, so quiet pixels never take up output bandwidth. Inside each group a rotating token picks one requesting pixel per cycle, grants it, and copies its record into a two-entry group buffer. A second rotating token chooses among the group buffers that hold data and loads one record per free slot into a single output register. That register drives a valid/ready stream.

An acquisition window is open while the shutter input is high. When the shutter falls, the block first sends every hit that was still waiting. It then appends one closing word that carries the 32-bit chip identifier.

Top module: `hit_pkt_fmt`

## Requirements
- R1: A hit word has the pixel address in bits [47:32], the header value 0xB in bits [31:28], the 14-bit arrival time in [27:14], the 10-bit time over threshold in [13:4] and the 4-bit fine arrival time in [3:0].
- R2: The pixel address is {column index (7 bits), group index (6 bits), pixel-in-group index (3 bits)}. Pixel k of the column belongs to group k/8 and has in-group index k%8.
- R3: No word is produced while no pixel requests and no shutter fall is pending.
- R4: In each group at most one grant is high in any cycle, and a grant is only ever given to a pixel whose request is high. A pixel's record is taken in the cycle its grant is high.
- R5: Within a group the token searches upward from the pixel after the last one granted, wrapping from 7 to 0. After reset the search starts at pixel 0.
- R6: Each group buffers at most two records. With the output stalled and the output register empty, one group therefore grants exactly three pixels and holds all other grants low.
- R7: Each falling edge of the shutter yields exactly one closing word: 0x71 in bits [47:40], 0xB0 in bits [39:32] and the chip identifier in [31:0].
- R8: The closing word follows every hit whose request was pending when the shutter fell.
- R9: Once the output valid is high, it stays high and the data stays unchanged until a cycle in which ready is high.
- R10: During reset the output valid and all grants are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shutter_i | input | 1 | Acquisition window, high while open |
| chip_id_i | input | 32 | Chip identifier placed in the closing word |
| dcol_i | input | 7 | Column index placed in the address |
| req_i | input | N_PIX | Per-pixel hit request |
| toa_i | input | N_PIX x 14 | Per-pixel arrival time |
| tot_i | input | N_PIX x 10 | Per-pixel time over threshold |
| ftoa_i | input | N_PIX x 4 | Per-pixel fine arrival time |
| gnt_o | output | N_PIX | Per-pixel grant; the record is taken while it is high |
| pkt_valid_o | output | 1 | Output word valid |
| pkt_ready_i | input | 1 | Output word accepted |
| pkt_data_o | output | 48 | Output word |

## Verification
The directed tests use several request patterns:
- A lone hit in the second group, which pins down the field and address packing.
- Three pixels of one group requesting together, followed by a pair that straddles the last grant. A fixed-priority pick and the rotating token give different orders for this pair.
- A whole group requesting against a stalled output. This shows the buffer depth through the number of pixels that get granted, and shows that the held word stays stable.
- A shutter fall with hits still queued across groups, and a fall with no hits at all. Together these show when the closing word is sent and that it is sent only once.
- A long idle stretch, which must stay silent.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  localparam int TOA_W   = 14;
  localparam int TOT_W   = 10;
  localparam int FTOA_W  = 4;
  localparam int DATA_W  = TOA_W + TOT_W + FTOA_W;
  localparam int DCOL_W  = 7;
  localparam int GIDX_W  = 6;
  localparam int PIDX_W  = 3;
  localparam int GRP_SZ  = 1 << PIDX_W;
  localparam int ENT_W   = PIDX_W + DATA_W;
  localparam int PKT_W   = 48;
  localparam int CHIP_W  = 32;
  localparam logic [3:0] HIT_HDR = 4'hB;
  localparam logic [7:0] EOC_HI  = 8'h71;
  localparam logic [7:0] EOC_LO  = 8'hB0;

  function automatic logic [PKT_W-1:0] pack_hit(
    input logic [DCOL_W-1:0] dcol,
    input logic [GIDX_W-1:0] gidx,
    input logic [ENT_W-1:0]  ent
  );
    return {dcol, gidx, ent[ENT_W-1:DATA_W], HIT_HDR, ent[DATA_W-1:0]};
  endfunction

  function automatic logic [PKT_W-1:0] pack_eoc(input logic [CHIP_W-1:0] id);
    return {EOC_HI, EOC_LO, id};
  endfunction
endpackage

// File: rtl/rr_token_arb.sv
module rr_token_arb #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] sel;
  logic          found;

  always_comb begin
    gnt_o = '0;
    sel   = last_q;
    found = 1'b0;
    for (int i = 1; i <= N; i++) begin
      int idx;
      idx = (int'(last_q) + i) % N;
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        sel        = IW'(idx);
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              last_q <= IW'(N - 1);
    else if (adv_i && found)  last_q <= sel;
  end
endmodule

// File: rtl/hit_buf.sv
module hit_buf #(
  parameter int W     = 31,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= din_i;
        wp_q        <= nxt(wp_q);
      end
      if (do_pop) rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/pix_group.sv
module pix_group
  import hpf_pkg::*;
#(
  parameter int BUF_DEPTH = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [GRP_SZ-1:0]             req_i,
  input  logic [GRP_SZ-1:0][DATA_W-1:0] hit_i,
  input  logic                          pop_i,
  output logic [GRP_SZ-1:0]             gnt_o,
  output logic [ENT_W-1:0]              ent_o,
  output logic                          avail_o
);
  logic [GRP_SZ-1:0] arb_gnt;
  logic              full, empty;
  logic [ENT_W-1:0]  push_ent;

  rr_token_arb #(.N(GRP_SZ)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .adv_i  (!full),
    .gnt_o  (arb_gnt)
  );

  assign gnt_o   = arb_gnt & {GRP_SZ{!full}};
  assign avail_o = !empty;

  always_comb begin
    push_ent = '0;
    for (int p = 0; p < GRP_SZ; p++)
      if (arb_gnt[p]) push_ent = {PIDX_W'(p), hit_i[p]};
  end

  hit_buf #(.W(ENT_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (|gnt_o),
    .din_i   (push_ent),
    .pop_i   (pop_i),
    .dout_o  (ent_o),
    .full_o  (full),
    .empty_o (empty)
  );
endmodule

// File: rtl/pkt_slot.sv
module pkt_slot
  import hpf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PKT_W-1:0] din_i,
  input  logic             ready_i,
  output logic             can_load_o,
  output logic             valid_o,
  output logic [PKT_W-1:0] data_o
);
  assign can_load_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (can_load_o) begin
      valid_o <= load_i;
      if (load_i) data_o <= din_i;
    end
  end
endmodule

// File: rtl/hit_pkt_fmt.sv
module hit_pkt_fmt
  import hpf_pkg::*;
#(
  parameter int N_GRP     = 2,
  parameter int BUF_DEPTH = 2,
  localparam int N_PIX    = N_GRP * GRP_SZ
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         shutter_i,
  input  logic [CHIP_W-1:0]            chip_id_i,
  input  logic [DCOL_W-1:0]            dcol_i,
  input  logic [N_PIX-1:0]             req_i,
  input  logic [N_PIX-1:0][TOA_W-1:0]  toa_i,
  input  logic [N_PIX-1:0][TOT_W-1:0]  tot_i,
  input  logic [N_PIX-1:0][FTOA_W-1:0] ftoa_i,
  output logic [N_PIX-1:0]             gnt_o,
  output logic                         pkt_valid_o,
  input  logic                         pkt_ready_i,
  output logic [PKT_W-1:0]             pkt_data_o
);
  logic [N_GRP-1:0]            grp_avail, grp_gnt, grp_pop;
  logic [N_GRP-1:0][ENT_W-1:0] grp_ent;
  logic                        can_load, load;
  logic [PKT_W-1:0]            load_word;
  logic                        shut_q, eoc_pend_q, eoc_load, shut_fall;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [GRP_SZ-1:0][DATA_W-1:0] hit;
    for (genvar p = 0; p < GRP_SZ; p++) begin : g_pix
      assign hit[p] = {toa_i[g*GRP_SZ+p], tot_i[g*GRP_SZ+p], ftoa_i[g*GRP_SZ+p]};
    end
    pix_group #(.BUF_DEPTH(BUF_DEPTH)) u_grp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i[g*GRP_SZ +: GRP_SZ]),
      .hit_i   (hit),
      .pop_i   (grp_pop[g]),
      .gnt_o   (gnt_o[g*GRP_SZ +: GRP_SZ]),
      .ent_o   (grp_ent[g]),
      .avail_o (grp_avail[g])
    );
  end

  rr_token_arb #(.N(N_GRP)) u_grp_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (grp_avail),
    .adv_i  (can_load),
    .gnt_o  (grp_gnt)
  );

  assign grp_pop = grp_gnt & {N_GRP{can_load}};

  // closing word waits until no live request and no buffered record remain
  assign shut_fall = shut_q && !shutter_i;
  assign eoc_load  = eoc_pend_q && can_load && !(|grp_avail) && !(|req_i);

  always_comb begin
    load_word = pack_eoc(chip_id_i);
    for (int g = 0; g < N_GRP; g++)
      if (grp_gnt[g]) load_word = pack_hit(dcol_i, GIDX_W'(g), grp_ent[g]);
  end

  assign load = (|grp_pop) || eoc_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shut_q     <= 1'b0;
      eoc_pend_q <= 1'b0;
    end else begin
      shut_q     <= shutter_i;
      eoc_pend_q <= (eoc_pend_q && !eoc_load) || shut_fall;
    end
  end

  pkt_slot u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .din_i      (load_word),
    .ready_i    (pkt_ready_i),
    .can_load_o (can_load),
    .valid_o    (pkt_valid_o),
    .data_o     (pkt_data_o)
  );
endmodule

// File: rtl/hit_pkt_fmt_chk.sv
module hit_pkt_fmt_chk #(
  parameter int N_GRP = 2,
  localparam int N_PIX = N_GRP * 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_PIX-1:0] req_i,
  input logic [N_PIX-1:0] gnt_o,
  input logic             pkt_valid_o,
  input logic             pkt_ready_i,
  input logic [47:0]      pkt_data_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_chk
    assert_one_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_o[g*8 +: 8]));
  end

  assert_grant_has_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);

  assert_hold_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> pkt_valid_o);

  assert_hold_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> $stable(pkt_data_o));

  assert_word_kind_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> (pkt_data_o[31:28] == 4'hB || pkt_data_o[47:32] == 16'h71B0));
endmodule

bind hit_pkt_fmt hit_pkt_fmt_chk #(.N_GRP(N_GRP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .gnt_o       (gnt_o),
  .pkt_valid_o (pkt_valid_o),
  .pkt_ready_i (pkt_ready_i),
  .pkt_data_o  (pkt_data_o)
);

// File: tb/tb_hit_pkt_fmt.sv
`timescale 1ns/1ps
module tb_hit_pkt_fmt;
  localparam int NG = 2;
  localparam int NP = NG * 8;
  localparam logic [31:0] CHIP = 32'h5EC0_1D42;
  localparam logic [6:0]  DCOL = 7'h55;

  logic clk = 1'b0, rst_n = 1'b0, shutter = 1'b1, ready = 1'b1;
  logic [NP-1:0]        req = '0;
  logic [NP-1:0][13:0]  toa = '0;
  logic [NP-1:0][9:0]   tot = '0;
  logic [NP-1:0][3:0]   ftoa = '0;
  logic [NP-1:0]        gnt;
  logic                 vld;
  logic [47:0]          dat;
  logic [47:0]          got[$];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hit_pkt_fmt #(.N_GRP(NG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .shutter_i(shutter), .chip_id_i(CHIP),
    .dcol_i(DCOL), .req_i(req), .toa_i(toa), .tot_i(tot), .ftoa_i(ftoa),
    .gnt_o(gnt), .pkt_valid_o(vld), .pkt_ready_i(ready), .pkt_data_o(dat));

  // pixel model: a granted record is handed over, request drops
  initial forever begin
    @(posedge clk);
    for (int k = 0; k < NP; k++) if (gnt[k]) req[k] <= 1'b0;
  end

  // output monitor
  initial forever begin
    @(posedge clk);
    if (rst_n && vld && ready) got.push_back(dat);
  end

  task automatic chk(input bit ok, input string r, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_hit(input int k);
    return {DCOL, 6'(k / 8), 3'(k % 8), 4'hB, toa[k], tot[k], ftoa[k]};
  endfunction

  task automatic set_hit(input int k);
    toa[k]  <= 14'(16'h1A00 + k * 37);
    tot[k]  <= 10'(10'h155 ^ k * 3);
    ftoa[k] <= 4'(k + 5);
    req[k]  <= 1'b1;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && req != '0; i++) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(vld == 1'b0, "R10", 48'(vld), 48'd0);
    chk(gnt == '0, "R10", 48'(gnt), 48'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_single();
    got.delete();
    set_hit(11);
    drain();
    chk(got.size() == 1, "R1", 48'(got.size()), 48'd1);
    if (got.size() > 0) begin
      chk(got[0] == exp_hit(11), "R1", got[0], exp_hit(11));
      chk(got[0][47:32] == {DCOL, 6'd1, 3'd3}, "R2", 48'(got[0][47:32]), 48'({DCOL, 6'd1, 3'd3}));
    end
  endtask

  task automatic t_rr();
    got.delete();
    set_hit(6); set_hit(1); set_hit(3);
    drain();
    chk(got.size() == 3, "R5", 48'(got.size()), 48'd3);
    if (got.size() == 3) begin
      chk(got[0][34:32] == 3'd1, "R5", 48'(got[0][34:32]), 48'd1);
      chk(got[1][34:32] == 3'd3, "R5", 48'(got[1][34:32]), 48'd3);
      chk(got[2][34:32] == 3'd6, "R5", 48'(got[2][34:32]), 48'd6);
    end
    got.delete();
    set_hit(2); set_hit(7);
    drain();
    chk(got.size() == 2, "R5", 48'(got.size()), 48'd2);
    if (got.size() == 2) begin
      chk(got[0][34:32] == 3'd7, "R5", 48'(got[0][34:32]), 48'd7);
      chk(got[1][34:32] == 3'd2, "R5", 48'(got[1][34:32]), 48'd2);
    end
  endtask

  task automatic t_grant();
    bit ok = 1'b1;
    got.delete();
    for (int k = 0; k < NP; k++) set_hit(k);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      for (int g = 0; g < NG; g++)
        if ($countones(gnt[g*8 +: 8]) > 1) ok = 1'b0;
      if ((gnt & ~req) != '0) ok = 1'b0;
    end
    chk(ok, "R4", 48'(gnt), 48'd0);
    drain();
    chk(got.size() == NP, "R4", 48'(got.size()), 48'(NP));
    for (int k = 0; k < NP; k++) begin
      bit seen = 1'b0;
      foreach (got[i]) if (got[i] == exp_hit(k)) seen = 1'b1;
      if (!seen) chk(1'b0, "R2", 48'(k), exp_hit(k));
    end
  endtask

  task automatic t_idle();
    got.delete();
    repeat (40) @(negedge clk);
    chk(got.size() == 0 && !vld, "R3", 48'(got.size()), 48'd0);
  endtask

  task automatic t_stall();
    logic [47:0] held;
    bit stable = 1'b1;
    got.delete();
    ready = 1'b0;
    for (int k = 0; k < 8; k++) set_hit(k);
    repeat (3) @(negedge clk);
    held = dat;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (!vld || dat != held) stable = 1'b0;
    end
    chk(stable, "R9", dat, held);
    chk($countones(req[7:0]) == 5, "R6", 48'(8 - $countones(req[7:0])), 48'd3);
    ready = 1'b1;
    drain();
    chk(got.size() == 8, "R6", 48'(got.size()), 48'd8);
  endtask

  task automatic t_eoc();
    int neoc = 0;
    got.delete();
    ready = 1'b0;
    set_hit(0); set_hit(9); set_hit(14); set_hit(5); set_hit(12);
    @(negedge clk);
    shutter = 1'b0;
    repeat (6) @(negedge clk);
    ready = 1'b1;
    drain();
    foreach (got[i]) if (got[i][47:32] == 16'h71B0) neoc++;
    chk(neoc == 1, "R7", 48'(neoc), 48'd1);
    chk(got.size() == 6, "R8", 48'(got.size()), 48'd6);
    if (got.size() > 0)
      chk(got[got.size()-1] == {8'h71, 8'hB0, CHIP}, "R8", got[got.size()-1], {8'h71, 8'hB0, CHIP});
    // window with no hits: only the closing word
    shutter = 1'b1;
    repeat (4) @(negedge clk);
    got.delete();
    shutter = 1'b0;
    repeat (10) @(negedge clk);
    chk(got.size() == 1, "R7", 48'(got.size()), 48'd1);
    if (got.size() == 1) chk(got[0] == {8'h71, 8'hB0, CHIP}, "R7", got[0], {8'h71, 8'hB0, CHIP});
    shutter = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #100000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_rr();
    t_grant();
    t_idle();
    t_stall();
    t_eoc();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule